// File: doc/BRIEF.md
# Rational-Rate Multi-Track Step Engine

This block moves twelve step tracks forward from a single master tempo pulse. Every track owns a rate written as a fraction of the master tempo, a loop length, a play direction and a step stride. A track can therefore run slower or faster than the master, and tracks with different lengths drift against each other and realign after the least common multiple of their lengths. Each time a track lands on a new step, the block reports the track number and the step index on its event port. It reports one event per clock cycle.

A track can also carry one modulation slot. When the track lands on a chosen step, it restarts a target track or rewrites that target's numerator, length or direction. The target may be the track itself. Software sets up the tracks through a narrow register write port. A restart input puts every track back to step 0 together.

The control path is a three-state machine:
- **IDLE**: waits for a tick. A tick arriving now, or one latched earlier, takes the transition *tick_seen* to ACCUM.
- **ACCUM**: adds each numerator to its track's accumulator in a single cycle, then always takes *accum_done* to DRAIN.
- **DRAIN**: each cycle, the lowest-numbered track whose accumulator has reached its denominator advances once and emits an event. When no track is ready, *drain_empty* returns to IDLE.
- A restart forces *restart_all* to IDLE from any state.

Top module: `track_step_engine`

## Requirements
- R1: After reset, or in the cycle after `restart_i`, no event is emitted. All steps are 0 and all accumulators are 0. Reset leaves every numerator at 0, so no track advances until it is configured.
- R2: On each tick a track adds its numerator to its accumulator. It advances once for each time the accumulator reaches its denominator, and the denominator is subtracted each time. A 1/4 track therefore advances on ticks 4, 8, and so on.
- R3: A rate above one yields several advances from one tick, one per clock cycle. Over n ticks the count is floor(n*num/den), for example 21 advances in 5 ticks at 21/5.
- R4: At most one event is emitted per cycle. The events from one tick come in consecutive cycles in ascending track order, and `ev_trk_o` is always below the track count.
- R5: Direction code 0 (forward) adds the stride modulo the length. Length 4 at rate 1/1 gives 1, 2, 3, 0, 1, 2.
- R6: Direction code 1 (reverse) subtracts the stride modulo the length. Length 5 from step 0 gives 4, 3, 2.
- R7: Direction code 2 (ping-pong) moves by one and turns at the first and last step without repeating them. Length 4 gives 1, 2, 3, 2, 1, 0, 1. A length of 1 stays at 0.
- R8: A stride s moves s steps per advance (reduced modulo the length), forward or backward with wrap. Length 8, stride 3 forward gives 3, 6, 1, 4; reverse gives 5, 2, 7.
- R9: Modulation op code 1 (restart) sets the target's step and accumulator to 0 when the source lands on its trigger step. An advance already due on the target in that drain is cancelled.
- R10: Modulation op codes 2, 3 and 4 set the target's numerator, length and direction from the modulation value, in the same cycle the source lands on its trigger step.
- R11: A written length or stride of 0 is treated as 1, and a length above the maximum is treated as the maximum. A denominator of 0 stops the track.
- R12: Two tracks at equal rate with lengths 4 and 5 are both at step 0 again after 20 advances.

Register select codes (`cfg_sel_i`): 0 numerator, 1 denominator, 2 length, 3 direction, 4 stride, 5 trigger step, 6 target track, 7 modulation op, 8 modulation value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Master tempo pulse, one cycle wide |
| restart_i | input | 1 | Clears all accumulators and returns every track to step 0 |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_trk_i | input | 4 | Track addressed by the write |
| cfg_sel_i | input | 4 | Field select code |
| cfg_data_i | input | 8 | Write data |
| ev_valid_o | output | 1 | A step event is present this cycle |
| ev_trk_o | output | 4 | Track that advanced |
| ev_step_o | output | 4 | Step the track landed on |

## Verification
The assertions check four things on every cycle:
- events come only out of DRAIN;
- events from one drain never go down in track number;
- ACCUM lasts exactly one cycle;
- a restart silences the event port.

Only the bench scenarios can show that the step sequences are right. This covers the rational rates, each direction, stride wrap, the clamps, polymetric realignment, and the result of a modulation on its target.

// File: rtl/track_step_pkg.sv
package track_step_pkg;

    typedef enum logic [1:0] {
        DIR_FWD = 2'd0,
        DIR_REV = 2'd1,
        DIR_PP  = 2'd2
    } dir_e;

    typedef enum logic [2:0] {
        MOD_NONE    = 3'd0,
        MOD_RESTART = 3'd1,
        MOD_SETNUM  = 3'd2,
        MOD_SETLEN  = 3'd3,
        MOD_SETDIR  = 3'd4
    } modop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DRAIN = 2'd2
    } state_e;

    localparam logic [3:0] SEL_NUM    = 4'd0;
    localparam logic [3:0] SEL_DEN    = 4'd1;
    localparam logic [3:0] SEL_LEN    = 4'd2;
    localparam logic [3:0] SEL_DIR    = 4'd3;
    localparam logic [3:0] SEL_STRIDE = 4'd4;
    localparam logic [3:0] SEL_MSTEP  = 4'd5;
    localparam logic [3:0] SEL_MTGT   = 4'd6;
    localparam logic [3:0] SEL_MOP    = 4'd7;
    localparam logic [3:0] SEL_MVAL   = 4'd8;

endpackage

// File: rtl/track_step_next.sv
module track_step_next
    import track_step_pkg::*;
#(
    parameter int SW = 4,
    parameter int LW = 5
) (
    input  logic [SW-1:0] step_i,
    input  logic [LW-1:0] len_i,
    input  dir_e          dir_i,
    input  logic [LW-1:0] stride_i,
    input  logic          up_i,
    output logic [SW-1:0] nxt_o,
    output logic          up_o
);
    logic [LW:0] s, l, m, sum;

    always_comb begin
        s    = (LW+1)'(step_i);
        l    = (LW+1)'(len_i);
        m    = (LW+1)'(stride_i % len_i);
        sum  = '0;
        up_o = up_i;
        if (s >= l) begin
            // position left outside a shortened loop: restart it
            sum  = '0;
            up_o = 1'b1;
        end else begin
            unique case (dir_i)
                DIR_REV: sum = (s >= m) ? s - m : s + l - m;
                DIR_PP: begin
                    if (l == 1) begin
                        sum = '0;
                    end else if (up_i) begin
                        if (s == l - 1) begin
                            sum  = s - 1;
                            up_o = 1'b0;
                        end else begin
                            sum = s + 1;
                        end
                    end else begin
                        if (s == 0) begin
                            sum  = 1;
                            up_o = 1'b1;
                        end else begin
                            sum = s - 1;
                        end
                    end
                end
                default: begin
                    sum = s + m;
                    if (sum >= l) sum = sum - l;
                end
            endcase
        end
        nxt_o = SW'(sum);
    end

endmodule

// File: rtl/track_lowest_pick.sv
module track_lowest_pick #(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/track_step_engine.sv
module track_step_engine
    import track_step_pkg::*;
#(
    parameter int NTRK    = 12,
    parameter int MAX_LEN = 16,
    parameter int RW      = 6,
    parameter int DW      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic                     restart_i,
    input  logic                     cfg_we_i,
    input  logic [$clog2(NTRK)-1:0]  cfg_trk_i,
    input  logic [3:0]               cfg_sel_i,
    input  logic [DW-1:0]            cfg_data_i,
    output logic                     ev_valid_o,
    output logic [$clog2(NTRK)-1:0]  ev_trk_o,
    output logic [$clog2(MAX_LEN)-1:0] ev_step_o
);
    localparam int TW = $clog2(NTRK);
    localparam int SW = $clog2(MAX_LEN);
    localparam int LW = $clog2(MAX_LEN + 1);
    localparam int AW = RW + 1;

    state_e state, state_nx;
    logic   tick_pend;

    logic [RW-1:0] num    [NTRK];
    logic [RW-1:0] den    [NTRK];
    logic [AW-1:0] acc    [NTRK];
    logic [LW-1:0] len    [NTRK];
    dir_e          dir    [NTRK];
    logic [LW-1:0] stride [NTRK];
    logic          up     [NTRK];
    logic [SW-1:0] step   [NTRK];
    logic [SW-1:0] mstep  [NTRK];
    logic [TW-1:0] mtgt   [NTRK];
    modop_e        mop    [NTRK];
    logic [DW-1:0] mval   [NTRK];

    logic [SW-1:0] nxt    [NTRK];
    logic          nxt_up [NTRK];
    logic [NTRK-1:0] ready;
    logic          any_rdy;
    logic [TW-1:0] pick;
    logic          adv, mod_fire;
    logic [TW-1:0] mod_tgt;

    function automatic logic [LW-1:0] clamp_len(input logic [DW-1:0] v);
        if (v == '0) return LW'(1);
        if (int'(v) > MAX_LEN) return LW'(MAX_LEN);
        return LW'(v);
    endfunction

    for (genvar g = 0; g < NTRK; g++) begin : g_trk
        track_step_next #(.SW(SW), .LW(LW)) u_next (
            .step_i  (step[g]),
            .len_i   (len[g]),
            .dir_i   (dir[g]),
            .stride_i(stride[g]),
            .up_i    (up[g]),
            .nxt_o   (nxt[g]),
            .up_o    (nxt_up[g])
        );
        assign ready[g] = (den[g] != '0) && (acc[g] >= AW'(den[g]));
    end

    track_lowest_pick #(.N(NTRK), .IW(TW)) u_pick (
        .req_i(ready),
        .any_o(any_rdy),
        .idx_o(pick)
    );

    assign adv      = (state == ST_DRAIN) && any_rdy;
    assign mod_fire = adv && (mop[pick] != MOD_NONE) && (nxt[pick] == mstep[pick]);
    assign mod_tgt  = mtgt[pick];

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tick_i || tick_pend) state_nx = ST_ACCUM;
            ST_ACCUM: state_nx = ST_DRAIN;
            ST_DRAIN: if (!any_rdy) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tick_pend <= 1'b0;
        end else if (restart_i) begin
            state     <= ST_IDLE;
            tick_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) tick_pend <= 1'b0;
            else if (tick_i)      tick_pend <= 1'b1;
        end
    end

    // track datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NTRK; t++) begin
                num[t] <= '0;        den[t] <= RW'(1);
                acc[t] <= '0;        len[t] <= LW'(MAX_LEN);
                dir[t] <= DIR_FWD;   stride[t] <= LW'(1);
                up[t]  <= 1'b1;      step[t] <= '0;
                mstep[t] <= '0;      mtgt[t] <= '0;
                mop[t] <= MOD_NONE;  mval[t] <= '0;
            end
        end else if (restart_i) begin
            for (int t = 0; t < NTRK; t++) begin
                acc[t]  <= '0;
                step[t] <= '0;
                up[t]   <= 1'b1;
            end
        end else begin
            if (state == ST_ACCUM) begin
                for (int t = 0; t < NTRK; t++) begin
                    if (den[t] != '0) acc[t] <= acc[t] + AW'(num[t]);
                end
            end
            if (adv) begin
                acc[pick]  <= acc[pick] - AW'(den[pick]);
                step[pick] <= nxt[pick];
                up[pick]   <= nxt_up[pick];
            end
            if (cfg_we_i && int'(cfg_trk_i) < NTRK) begin
                unique case (cfg_sel_i)
                    SEL_NUM:    num[cfg_trk_i]    <= RW'(cfg_data_i);
                    SEL_DEN:    den[cfg_trk_i]    <= RW'(cfg_data_i);
                    SEL_LEN:    len[cfg_trk_i]    <= clamp_len(cfg_data_i);
                    SEL_DIR:    dir[cfg_trk_i]    <= dir_e'(cfg_data_i[1:0]);
                    SEL_STRIDE: stride[cfg_trk_i] <= clamp_len(cfg_data_i);
                    SEL_MSTEP:  mstep[cfg_trk_i]  <= SW'(cfg_data_i);
                    SEL_MTGT:   mtgt[cfg_trk_i]   <= TW'(cfg_data_i);
                    SEL_MOP:    mop[cfg_trk_i]    <= modop_e'(cfg_data_i[2:0]);
                    SEL_MVAL:   mval[cfg_trk_i]   <= cfg_data_i;
                    default: ;
                endcase
            end
            if (mod_fire && int'(mod_tgt) < NTRK) begin
                unique case (mop[pick])
                    MOD_RESTART: begin
                        step[mod_tgt] <= '0;
                        acc[mod_tgt]  <= '0;
                        up[mod_tgt]   <= 1'b1;
                    end
                    MOD_SETNUM: num[mod_tgt] <= RW'(mval[pick]);
                    MOD_SETLEN: len[mod_tgt] <= clamp_len(mval[pick]);
                    MOD_SETDIR: dir[mod_tgt] <= dir_e'(mval[pick][1:0]);
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_valid_o <= 1'b0;
            ev_trk_o   <= '0;
            ev_step_o  <= '0;
        end else if (restart_i) begin
            ev_valid_o <= 1'b0;
        end else begin
            ev_valid_o <= adv;
            if (adv) begin
                ev_trk_o  <= pick;
                ev_step_o <= nxt[pick];
            end
        end
    end

endmodule

// File: rtl/track_step_engine_chk.sv
module track_step_engine_chk
    import track_step_pkg::*;
#(
    parameter int NTRK = 12,
    parameter int TW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          restart_i,
    input logic          cfg_we_i,
    input logic          ev_valid_o,
    input logic [TW-1:0] ev_trk_o,
    input state_e        state_i
);
    // R4
    trk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> (int'(ev_trk_o) < NTRK));

    // R4
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && $past(ev_valid_o) && !$past(cfg_we_i) && !$past(cfg_we_i, 2))
        |-> (ev_trk_o >= $past(ev_trk_o)));

    // R2
    drain_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> ($past(state_i) == ST_DRAIN));

    // R1
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!ev_valid_o && state_i == ST_IDLE));

    // R3
    accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_ACCUM && !restart_i) |=> (state_i == ST_DRAIN && !ev_valid_o));
endmodule

bind track_step_engine track_step_engine_chk #(.NTRK(NTRK), .TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_i),
    .cfg_we_i  (cfg_we_i),
    .ev_valid_o(ev_valid_o),
    .ev_trk_o  (ev_trk_o),
    .state_i   (state)
);

// File: tb/test_track_step_engine.sv
module test_track_step_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       restart_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [3:0] cfg_trk_i = '0;
    logic [3:0] cfg_sel_i = '0;
    logic [7:0] cfg_data_i = '0;
    logic       ev_valid_o;
    logic [3:0] ev_trk_o;
    logic [3:0] ev_step_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc    = 0;
    int cnt  [16];
    int last [16];
    int log_trk [64];
    int log_cyc [64];
    int nlog = 0;

    always #10 clk = ~clk;

    track_step_engine i_track_step_engine (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .restart_i(restart_i),
        .cfg_we_i(cfg_we_i), .cfg_trk_i(cfg_trk_i), .cfg_sel_i(cfg_sel_i),
        .cfg_data_i(cfg_data_i), .ev_valid_o(ev_valid_o), .ev_trk_o(ev_trk_o),
        .ev_step_o(ev_step_o)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n && ev_valid_o) begin
            cnt[ev_trk_o]++;
            last[ev_trk_o] = int'(ev_step_o);
            if (nlog < 64) begin
                log_trk[nlog] = int'(ev_trk_o);
                log_cyc[nlog] = cyc;
                nlog++;
            end
        end
    end

    // num, den, len, dir, stride, ticks, expected count, expected step, requirement
    localparam int VEC [14][9] = '{
        '{ 1, 1,  4, 0,  1,  6,  6, 2,  5},  // R5 forward wrap
        '{ 1, 4,  8, 0,  1,  9,  2, 2,  2},  // R2 slow rate
        '{ 5, 4, 16, 0,  1,  4,  5, 5,  3},  // R3 5/4
        '{21, 5, 13, 0,  1,  5, 21, 8,  3},  // R3 21/5
        '{ 1, 1,  5, 1,  1,  3,  3, 2,  6},  // R6 reverse
        '{ 1, 1,  4, 2,  1,  7,  7, 1,  7},  // R7 ping-pong
        '{ 2, 1,  3, 2,  1,  2,  4, 0,  7},  // R7 ping-pong at 2/1
        '{ 1, 1,  1, 2,  1,  3,  3, 0,  7},  // R7 length one
        '{ 1, 1,  8, 0,  3,  4,  4, 4,  8},  // R8 jump forward
        '{ 1, 1,  8, 1,  3,  3,  3, 7,  8},  // R8 jump backward
        '{ 1, 1,  8, 0, 10,  2,  2, 4,  8},  // R8 stride above length
        '{ 1, 1,  0, 0,  1,  3,  3, 0, 11},  // R11 length 0 -> 1
        '{ 1, 1, 31, 0,  1, 17, 17, 1, 11},  // R11 length above max
        '{ 1, 0,  8, 0,  1,  3,  0, 0, 11}   // R11 denominator 0 stops
    };

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int t, input int sel, input int d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_trk_i = 4'(t); cfg_sel_i = 4'(sel); cfg_data_i = 8'(d);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            repeat (40) @(negedge clk);
        end
    endtask

    task automatic do_restart();
        @(negedge clk); restart_i = 1'b1;
        @(negedge clk); restart_i = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk);
        for (int t = 0; t < 16; t++) begin cnt[t] = 0; last[t] = 0; end
        nlog = 0;
    endtask

    task automatic clear_all();
        for (int t = 0; t < 12; t++) begin
            wr(t, 0, 0); wr(t, 1, 1); wr(t, 2, 16); wr(t, 3, 0);
            wr(t, 4, 1); wr(t, 7, 0); wr(t, 5, 0); wr(t, 6, 0);
        end
        do_restart();
        clear_log();
    endtask

    task automatic trk(input int t, input int n, input int len, input int dir);
        wr(t, 1, 1); wr(t, 2, len); wr(t, 3, dir); wr(t, 0, n);
    endtask

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state: quiet port, unconfigured tracks do not move
        chk("R1", int'(ev_valid_o), 0, "event after reset");
        tick_n(2);
        chk("R1", nlog, 0, "events from unconfigured tracks");

        for (int i = 0; i < 14; i++) begin
            clear_all();
            wr(0, 1, VEC[i][1]); wr(0, 2, VEC[i][2]); wr(0, 3, VEC[i][3]);
            wr(0, 4, VEC[i][4]); wr(0, 0, VEC[i][0]);
            tick_n(VEC[i][5]);
            chk($sformatf("R%0d", VEC[i][8]), cnt[0], VEC[i][6], $sformatf("row %0d count", i));
            chk($sformatf("R%0d", VEC[i][8]), last[0], VEC[i][7], $sformatf("row %0d step", i));
        end

        // R4 ordering: tracks 1, 3 at 1/1 and 7 at 2/1 on one tick
        clear_all();
        trk(1, 1, 8, 0); trk(3, 1, 8, 0); trk(7, 2, 8, 0);
        tick_n(1);
        chk("R4", nlog, 4, "event count");
        chk("R4", log_trk[0], 1, "first track");
        chk("R4", log_trk[1], 3, "second track");
        chk("R4", log_trk[2], 7, "third track");
        chk("R4", log_trk[3], 7, "fourth track");
        chk("R4", log_cyc[3] - log_cyc[0], 3, "cycles spanned");

        // R12 polymeter realignment
        clear_all();
        trk(0, 1, 4, 0); trk(1, 1, 5, 0);
        tick_n(4);
        chk("R12", last[0] * 16 + last[1], 0 * 16 + 4, "steps after 4");
        tick_n(16);
        chk("R12", last[0] * 16 + last[1], 0, "steps after 20");
        chk("R12", cnt[0] + cnt[1], 40, "advances after 20");

        // R1 restart clears accumulators and steps
        clear_all();
        trk(0, 1, 8, 0); wr(0, 1, 4);
        trk(1, 1, 8, 0);
        tick_n(3);
        chk("R1", last[1], 3, "step before restart");
        do_restart();
        @(negedge clk);
        chk("R1", int'(ev_valid_o), 0, "event after restart");
        clear_log();
        tick_n(1);
        chk("R1", cnt[0], 0, "1/4 track after restart");
        chk("R1", last[1], 1, "1/1 track after restart");

        // R9 restart modulation from track 0 step 2 onto track 1
        clear_all();
        trk(0, 1, 8, 0); trk(1, 1, 8, 0);
        wr(0, 5, 2); wr(0, 6, 1); wr(0, 7, 1);
        tick_n(5);
        chk("R9", last[1], 3, "target step");
        chk("R9", cnt[1], 4, "target advances");

        // R10 self modulation: length, numerator, direction
        clear_all();
        trk(2, 1, 8, 0); wr(2, 5, 1); wr(2, 6, 2); wr(2, 8, 3); wr(2, 7, 3);
        trk(3, 1, 8, 0); wr(3, 5, 1); wr(3, 6, 3); wr(3, 8, 2); wr(3, 7, 2);
        trk(4, 1, 8, 0); wr(4, 5, 2); wr(4, 6, 4); wr(4, 8, 1); wr(4, 7, 4);
        tick_n(3);
        chk("R10", last[2], 0, "set length wrap");
        tick_n(1);
        chk("R10", last[3], 7, "set numerator step");
        chk("R10", cnt[3], 7, "set numerator advances");
        chk("R10", last[4], 0, "set direction step");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule